// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Engine

This block is the host-side engine of an enhanced parallel port. A single host register access to one of the handshaked port offsets becomes one complete address or data cycle on the parallel bus. The engine drives the byte, the write qualifier and the address or data strobe, and it follows the peripheral's active-low wait line through every phase of the cycle. The host sees `host_busy` for as long as the cycle runs. A one-cycle `host_done` pulse marks the moment the access completes, and it carries the read byte.

When no handshaked cycle is running, the port acts as a plain standard port. A control register sets the three control pins and the direction of the data bus. A watchdog bounds each handshaked cycle. If the peripheral stalls, the watchdog aborts the cycle, releases the strobes and raises a sticky time-out flag. The host clears that flag by writing 1 to it.

Top module: `epp_cycle_engine`

## Requirements
- R1: Offsets 0, 1 and 2 complete in one cycle with no strobe activity. Offset 0 is the data latch. Offset 1 is status: bit 0 is the time-out flag and bit 7 is the synchronized level of `wait_n_i`. Offset 2 is control: bit 0 is STROBE, bit 1 is AUTOFD, bit 2 is INIT and bit 5 is the direction bit, where 1 means input. All registers reset to 0.
- R2: Outside a handshaked cycle, `stb_n_o`, `afd_n_o` and `ini_n_o` are the inverses of control bits 0, 1 and 2. `pd_oe` is the inverse of control bit 5 and `pd_o` shows the data latch. `write_n_o`, `dstb_n_o` and `astb_n_o` are all high.
- R3: With `epp_en` high, an access to offset 3 runs a cycle on `astb_n_o`, and an access to offsets 4 to 7 runs a cycle on `dstb_n_o`. With `epp_en` low, these offsets complete in one cycle with no strobe, writes have no effect and reads return 8'hFF. The two strobes are never low together.
- R4: After a cycle starts, the engine changes none of `write_n_o`, `pd_oe`, `pd_o` or the strobes until the synchronized `wait_n_i` is low.
- R5: In a write cycle, the byte, `pd_oe`=1 and `write_n_o`=0 are presented one clock before the strobe falls, and they stay unchanged while the strobe falls.
- R6: Once the synchronized `wait_n_i` is high during the strobe, the strobe rises and `host_done` pulses in the same clock. A read returns the bus byte sampled in that last strobe clock.
- R7: After the strobe rises, `write_n_o` and the data bus stay unchanged and `host_busy` stays high until the synchronized `wait_n_i` is low again.
- R8: When control bit 0 is set, every handshaked cycle is a write. On a host read, the engine drives the data latch.
- R9: A host write while control bit 5 is set runs a read-style cycle: `write_n_o` stays high and the bus is not driven. The time-out flag is not set.
- R10: If a cycle has not reached the strobe-release point within CLK_HZ*TMO_NS/1e9 clocks of its start, it is aborted. The strobes return high, `host_done` pulses with read data 8'hFF, `host_busy` drops and status bit 0 is set.
- R11: The time-out flag stays set until the host writes offset 1 with bit 0 equal to 1. A write with bit 0 equal to 0 leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| epp_en | input | 1 | Enables the handshaked offsets 3 to 7 |
| host_req | input | 1 | One-clock request; sampled only while `host_busy` is low |
| host_wr | input | 1 | 1 = write access |
| host_off | input | 3 | Register offset |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte, valid with `host_done` |
| host_done | output | 1 | One-clock pulse when the access completes |
| host_busy | output | 1 | High while a handshaked cycle is in progress |
| pd_o | output | 8 | Data bus output value |
| pd_i | input | 8 | Data bus input value |
| pd_oe | output | 1 | 1 = engine drives the data bus |
| write_n_o | output | 1 | Active-low write qualifier |
| dstb_n_o | output | 1 | Active-low data strobe |
| astb_n_o | output | 1 | Active-low address strobe |
| wait_n_i | input | 1 | Peripheral wait/ready line, asynchronous |
| stb_n_o | output | 1 | Standard-port strobe pin |
| afd_n_o | output | 1 | Standard-port auto-feed pin |
| ini_n_o | output | 1 | Standard-port init pin |

## Verification
The bench starts one handshaked cycle with the wait line already high. An engine that skips the wait-low gate would drop a strobe or the write qualifier early. It sets the direction bit and then attempts a write. A design that ignores the direction bit would drive the bus or flag an error. With the STROBE bit set, it issues a host read. A design without the override would float the bus and leave `write_n_o` high. Finally, it leaves a peripheral stalled. An off-by-one or missing watchdog would then complete too early, too late or never, and it would leave the sticky flag wrong for the clear-by-writing-1 checks.

// File: rtl/epp_pkg.sv
package epp_pkg;
    localparam int OFFW = 3;
    localparam int DW   = 8;

    localparam logic [OFFW-1:0] OFF_DATA = 3'd0;
    localparam logic [OFFW-1:0] OFF_STAT = 3'd1;
    localparam logic [OFFW-1:0] OFF_CTRL = 3'd2;
    localparam logic [OFFW-1:0] OFF_ADDR = 3'd3;

    localparam int CB_STROBE = 0;
    localparam int CB_AUTOFD = 1;
    localparam int CB_INIT   = 2;
    localparam int CB_DIRIN  = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_SETUP,
        ST_STRB,
        ST_END
    } epp_state_e;

    typedef struct packed {
        epp_state_e    state;
        logic          tmo;
        logic [DW-1:0] ctrl;
        logic [DW-1:0] dat;
        logic          cyc_wr;
        logic          cyc_addr;
        logic          cyc_hrd;
        logic [DW-1:0] cyc_byte;
        logic [DW-1:0] rdata;
        logic          done;
    } eng_s;
endpackage

// File: rtl/epp_sync.sv
module epp_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/epp_wdog.sv
module epp_wdog #(
    parameter int LIMIT = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int W = $clog2(LIMIT + 1);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = run ? cnt_q + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = run && (cnt_q == W'(LIMIT - 1));
endmodule

// File: rtl/epp_cycle_engine.sv
module epp_cycle_engine
    import epp_pkg::*;
#(
    parameter int CLK_HZ      = 125_000_000,
    parameter int TMO_NS      = 10_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          epp_en,
    input  logic          host_req,
    input  logic          host_wr,
    input  logic [OFFW-1:0] host_off,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          host_done,
    output logic          host_busy,
    output logic [DW-1:0] pd_o,
    input  logic [DW-1:0] pd_i,
    output logic          pd_oe,
    output logic          write_n_o,
    output logic          dstb_n_o,
    output logic          astb_n_o,
    input  logic          wait_n_i,
    output logic          stb_n_o,
    output logic          afd_n_o,
    output logic          ini_n_o
);
    localparam longint PROD    = longint'(CLK_HZ) * longint'(TMO_NS);
    localparam int     TMO_CYC = int'(PROD / 64'd1_000_000_000);
    localparam int     WD_LIM  = (TMO_CYC < 2) ? 2 : TMO_CYC;

    eng_s d, q;
    logic wait_s;
    logic wd_run, wd_expire;
    logic in_cyc;

    epp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (wait_n_i),
        .dout (wait_s)
    );

    assign wd_run = (q.state == ST_ARM) || (q.state == ST_SETUP) || (q.state == ST_STRB);

    epp_wdog #(.LIMIT(WD_LIM)) u_wdog (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (wd_run),
        .expire(wd_expire)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (host_req) begin
                    if (host_off == OFF_DATA) begin
                        if (host_wr) d.dat = host_wdata;
                        else         d.rdata = pd_i;
                        d.done = 1'b1;
                    end else if (host_off == OFF_STAT) begin
                        if (host_wr) begin
                            if (host_wdata[0]) d.tmo = 1'b0;
                        end else begin
                            d.rdata = {wait_s, 6'd0, q.tmo};
                        end
                        d.done = 1'b1;
                    end else if (host_off == OFF_CTRL) begin
                        if (host_wr) d.ctrl = host_wdata;
                        else         d.rdata = q.ctrl;
                        d.done = 1'b1;
                    end else if (!epp_en) begin
                        if (!host_wr) d.rdata = 8'hFF;
                        d.done = 1'b1;
                    end else begin
                        d.state    = ST_ARM;
                        d.cyc_addr = (host_off == OFF_ADDR);
                        d.cyc_hrd  = !host_wr;
                        d.cyc_wr   = (host_wr && !q.ctrl[CB_DIRIN]) || q.ctrl[CB_STROBE];
                        d.cyc_byte = host_wr ? host_wdata : q.dat;
                    end
                end
            end
            ST_ARM: begin
                if (!wait_s) d.state = ST_SETUP;
            end
            ST_SETUP: begin
                d.state = ST_STRB;
            end
            ST_STRB: begin
                if (wait_s) begin
                    d.state = ST_END;
                    d.done  = 1'b1;
                    if (q.cyc_hrd) d.rdata = pd_i;
                end
            end
            ST_END: begin
                if (!wait_s) d.state = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase
        if (wd_expire) begin
            d.state = ST_IDLE;
            d.tmo   = 1'b1;
            d.rdata = 8'hFF;
            d.done  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign in_cyc     = (q.state == ST_SETUP) || (q.state == ST_STRB) || (q.state == ST_END);
    assign write_n_o  = !(in_cyc && q.cyc_wr);
    assign pd_oe      = in_cyc ? q.cyc_wr : !q.ctrl[CB_DIRIN];
    assign pd_o       = in_cyc ? q.cyc_byte : q.dat;
    assign dstb_n_o   = !((q.state == ST_STRB) && !q.cyc_addr);
    assign astb_n_o   = !((q.state == ST_STRB) && q.cyc_addr);
    assign stb_n_o    = !q.ctrl[CB_STROBE];
    assign afd_n_o    = !q.ctrl[CB_AUTOFD];
    assign ini_n_o    = !q.ctrl[CB_INIT];
    assign host_rdata = q.rdata;
    assign host_done  = q.done;
    assign host_busy  = (q.state != ST_IDLE);
endmodule

// File: rtl/epp_cycle_engine_chk.sv
module epp_cycle_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic epp_en,
    input logic host_done,
    input logic host_busy,
    input logic pd_oe,
    input logic write_n_o,
    input logic dstb_n_o,
    input logic astb_n_o
);
    assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dstb_n_o && !astb_n_o));

    assert_no_strobe_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !epp_en |-> (dstb_n_o && astb_n_o));

    assert_quiet_at_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_busy) |-> (write_n_o && dstb_n_o && astb_n_o));

    assert_setup_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dstb_n_o) || $fell(astb_n_o)) |-> ($stable(write_n_o) && $stable(pd_oe)));

    assert_release_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |-> (dstb_n_o && astb_n_o));

    assert_strobe_inside_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!dstb_n_o || !astb_n_o) |-> host_busy);
endmodule

bind epp_cycle_engine epp_cycle_engine_chk u_chk (.*);

// File: tb/sim_epp_cycle_engine.sv
module sim_epp_cycle_engine;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic epp_en = 1'b1;
    logic host_req = 1'b0, host_wr = 1'b0;
    logic [2:0] host_off = '0;
    logic [7:0] host_wdata = '0, pd_i = '0;
    logic [7:0] host_rdata, pd_o;
    logic host_done, host_busy, pd_oe, write_n_o, dstb_n_o, astb_n_o;
    logic wait_n_i = 1'b0;
    logic stb_n_o, afd_n_o, ini_n_o;

    int checks = 0, errors = 0;
    localparam int LIMIT = 1250;

    always #4 clk = ~clk;

    epp_cycle_engine u0 (.*);

    typedef struct packed {
        logic [7:0] ctrl; logic [2:0] off; logic wr; logic [7:0] wd; logic [7:0] pin;
        logic astb; logic wrn; logic oe; logic [7:0] pd; logic chk_rd; logic [7:0] rd;
    } vec_t;

    localparam vec_t VEC [7] = '{
        '{8'h04, 3'd3, 1'b1, 8'hA5, 8'h00, 1'b1, 1'b0, 1'b1, 8'hA5, 1'b0, 8'h00},
        '{8'h04, 3'd4, 1'b1, 8'h3C, 8'h00, 1'b0, 1'b0, 1'b1, 8'h3C, 1'b0, 8'h00},
        '{8'h04, 3'd7, 1'b1, 8'h81, 8'h00, 1'b0, 1'b0, 1'b1, 8'h81, 1'b0, 8'h00},
        '{8'h04, 3'd5, 1'b0, 8'h00, 8'h5A, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 8'h5A},
        '{8'h24, 3'd6, 1'b1, 8'h77, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00},
        '{8'h05, 3'd4, 1'b0, 8'h00, 8'h66, 1'b0, 1'b0, 1'b1, 8'hC3, 1'b0, 8'h00},
        '{8'h04, 3'd3, 1'b0, 8'h00, 8'h12, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 8'h12}
    };

    logic seen, s_astb, s_dstb, s_wrn, s_oe, s_prev_wrn, s_prev_oe, early_bad, held_ok;
    logic [7:0] s_pd;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic access(input bit wr, input logic [2:0] off, input logic [7:0] wd,
                          input int hold_hi, input bit respond,
                          output logic [7:0] rd, output int lat);
        logic pw, po;
        seen = 0; early_bad = 0; held_ok = 1; lat = 0;
        if (hold_hi > 0) wait_n_i = 1'b1;
        @(negedge clk);
        host_req = 1'b1; host_wr = wr; host_off = off; host_wdata = wd;
        pw = write_n_o; po = pd_oe;
        forever begin
            @(negedge clk);
            host_req = 1'b0;
            lat++;
            if (hold_hi > 0 && lat < hold_hi) begin
                if (!write_n_o || !dstb_n_o || !astb_n_o || pd_oe != po) early_bad = 1;
            end
            if (hold_hi > 0 && lat == hold_hi) wait_n_i = 1'b0;
            if ((!dstb_n_o || !astb_n_o) && !seen) begin
                seen = 1; s_astb = !astb_n_o; s_dstb = !dstb_n_o;
                s_wrn = write_n_o; s_oe = pd_oe; s_pd = pd_o;
                s_prev_wrn = pw; s_prev_oe = po;
                if (respond) wait_n_i = 1'b1;
            end
            pw = write_n_o; po = pd_oe;
            if (host_done) begin
                rd = host_rdata;
                break;
            end
            if (lat > 5000) break;
        end
        if (host_busy) begin
            for (int i = 0; i < 4; i++) begin
                if (write_n_o != s_wrn || pd_oe != s_oe || !dstb_n_o || !astb_n_o) held_ok = 0;
                @(negedge clk);
            end
            wait_n_i = 1'b0;
            for (int i = 0; i < 20 && host_busy; i++) begin
                if (write_n_o != s_wrn) held_ok = 0;
                @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        logic [7:0] rd;
        int lat;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1 R2 reset state
        chk(!host_busy, "R1 busy after reset", host_busy, 0);
        chk(write_n_o && dstb_n_o && astb_n_o, "R2 handshake pins idle", {write_n_o, dstb_n_o, astb_n_o}, 7);
        chk(stb_n_o && afd_n_o && ini_n_o && pd_oe && pd_o == 0, "R2 control pins reset",
            {stb_n_o, afd_n_o, ini_n_o, pd_oe}, 15);
        access(0, 3'd1, 8'h00, 0, 1, rd, lat);
        chk(rd == 8'h00 && lat == 1, "R1 status reset", rd, 0);
        // R2 pass-through
        access(1, 3'd2, 8'h07, 0, 1, rd, lat);
        @(negedge clk);
        chk(!stb_n_o && !afd_n_o && !ini_n_o, "R2 control bits drive pins", {stb_n_o, afd_n_o, ini_n_o}, 0);
        access(1, 3'd2, 8'h20, 0, 1, rd, lat);
        @(negedge clk);
        chk(!pd_oe, "R2 direction bit floats bus", pd_oe, 0);
        access(0, 3'd2, 8'h00, 0, 1, rd, lat);
        chk(rd == 8'h20, "R1 control readback", rd, 8'h20);
        access(1, 3'd0, 8'hC3, 0, 1, rd, lat);
        access(1, 3'd2, 8'h00, 0, 1, rd, lat);
        @(negedge clk);
        chk(pd_oe && pd_o == 8'hC3, "R2 data latch on bus", pd_o, 8'hC3);

        // R3 R5 R6 R7 R8 R9 table walk
        for (int v = 0; v < 7; v++) begin
            access(1, 3'd2, VEC[v].ctrl, 0, 1, rd, lat);
            pd_i = VEC[v].pin;
            access(VEC[v].wr, VEC[v].off, VEC[v].wd, 0, 1, rd, lat);
            chk(seen && s_astb == VEC[v].astb && s_dstb == !VEC[v].astb, "R3 strobe select", s_astb, VEC[v].astb);
            chk(s_wrn == VEC[v].wrn && s_oe == VEC[v].oe, "R8 R9 cycle direction", {s_wrn, s_oe}, {VEC[v].wrn, VEC[v].oe});
            if (VEC[v].oe) chk(s_pd == VEC[v].pd, "R5 byte on bus", s_pd, VEC[v].pd);
            chk(s_prev_wrn == s_wrn && s_prev_oe == s_oe, "R5 setup before strobe", s_prev_wrn, s_wrn);
            chk(held_ok && !host_busy, "R7 hold until wait low", held_ok, 1);
            if (VEC[v].chk_rd) chk(rd == VEC[v].rd, "R6 read byte", rd, VEC[v].rd);
            access(0, 3'd1, 8'h00, 0, 1, rd, lat);
            chk(rd[0] == 1'b0, "R9 no error flag", rd[0], 0);
        end
        access(1, 3'd2, 8'h04, 0, 1, rd, lat);

        // R4 wait already high at start
        access(1, 3'd4, 8'h99, 15, 1, rd, lat);
        chk(!early_bad && seen && s_wrn == 1'b0, "R4 gate on wait low", early_bad, 0);

        // R3 disabled offsets
        epp_en = 1'b0;
        access(1, 3'd4, 8'h55, 0, 1, rd, lat);
        chk(!seen && lat == 1, "R3 disabled write no cycle", lat, 1);
        access(0, 3'd5, 8'h00, 0, 1, rd, lat);
        chk(!seen && rd == 8'hFF, "R3 disabled read FF", rd, 8'hFF);
        epp_en = 1'b1;

        // R10 stalled peripheral
        access(1, 3'd4, 8'h42, 0, 0, rd, lat);
        chk(lat >= LIMIT && lat <= LIMIT + 2, "R10 abort latency", lat, LIMIT + 1);
        chk(rd == 8'hFF && !host_busy && dstb_n_o && astb_n_o, "R10 abort release", rd, 8'hFF);
        access(0, 3'd1, 8'h00, 0, 1, rd, lat);
        chk(rd[0] == 1'b1, "R10 flag set", rd[0], 1);

        // R11 clear by writing 1
        access(1, 3'd1, 8'h00, 0, 1, rd, lat);
        access(0, 3'd1, 8'h00, 0, 1, rd, lat);
        chk(rd[0] == 1'b1, "R11 write 0 keeps flag", rd[0], 1);
        access(1, 3'd1, 8'h01, 0, 1, rd, lat);
        access(0, 3'd1, 8'h00, 0, 1, rd, lat);
        chk(rd[0] == 1'b0, "R11 write 1 clears flag", rd[0], 0);
        access(1, 3'd4, 8'h11, 0, 1, rd, lat);
        chk(seen && lat < 20, "R10 normal cycle after abort", lat, 10);

        summary();
    end
endmodule